// File: doc/BRIEF.md
# Multi-Unit 32-bit ALU with Flags

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. Two operands and a 4-bit operation code go in. A 32-bit result and three status flags come out. Inside, four dedicated sub-units work in parallel on the same operands:

- an adder/subtractor,
- a relational comparator,
- a bitwise logic unit,
- a barrel shifter that also rotates.

The operation code chooses which sub-unit's output appears at the result port. The block holds no state. A surrounding pipeline or single-cycle datapath registers the result wherever its timing calls for it.

The carry and overflow flags describe the adder/subtractor only, and they read 0 for every other operation. The zero flag always describes the 32-bit value that is presented on the result port. Relational operations return the integer 1 for true and 0 for false, so the result can be stored directly into a general register.

Top module: `alu32_flags`

## Requirements
- R1: Operation code 4'b0000 (ADD) gives result = (A + B) mod 2^32, and the carry flag equals the carry out of bit 31 of that sum.
- R2: Operation code 4'b0001 (SUB) gives result = (A - B) mod 2^32, computed as A + ~B + 1. The carry flag is the raw carry out of bit 31 of that sum, so it is 1 exactly when A >= B as unsigned numbers.
- R3: For ADD and SUB, the overflow flag is 1 exactly when the signed two's-complement result falls outside [-2^31, 2^31-1].
- R4: The zero flag is 1 exactly when the 32-bit result on the result port is 0, for every operation code.
- R5: For every operation code other than ADD and SUB, the carry and overflow flags are 0.
- R6: Operation codes 4'b0010 AND, 4'b0011 OR, 4'b0100 NOR and 4'b0101 XOR give the bitwise function of A and B.
- R7: Operation codes 4'b0110 SLL, 4'b0111 SRL and 4'b1000 SRA shift A by B[4:0]. SRL fills with zeros and SRA fills with copies of A[31]. B[31:5] has no effect, and an amount of 0 returns A unchanged.
- R8: Operation codes 4'b1001 ROL and 4'b1010 ROR rotate A left or right by B[4:0]. Bits leaving one end re-enter at the other, and B[31:5] has no effect.
- R9: Operation codes 4'b1011 EQ and 4'b1100 NE compare A and B for equality. The result is 32'd1 when the relation holds and 32'd0 otherwise.
- R10: Operation codes 4'b1101 GE and 4'b1110 LT compare A and B as signed two's-complement numbers. The result is 32'd1 when the relation holds and 32'd0 otherwise.
- R11: The unused operation code 4'b1111 gives result 0, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B); bits [4:0] give the shift/rotate amount |
| op_code | input | 4 | Operation select |
| result | output | 32 | Result of the selected sub-unit |
| flag_carry | output | 1 | Carry out of bit 31 for ADD/SUB, else 0 |
| flag_zero | output | 1 | Result equals zero |
| flag_ovf | output | 1 | Signed overflow for ADD/SUB, else 0 |

## Verification
Some properties are checked by assertions every time the inputs change:

- the adder agrees with plain arithmetic;
- overflow is raised only when the result sign disagrees with the first operand;
- EQ/NE and GE/LT are always complementary;
- AND never sets a bit that OR leaves clear;
- rotation keeps the number of set bits;
- an arithmetic right shift keeps the sign bit;
- a zero shift passes A through;
- the flags are quiet for operations that are not arithmetic.

Other behaviour can only be shown by the bench's scenarios, because a cheap invariant cannot capture it:

- the exact values of the shift fill;
- the carry as unsigned borrow at equal operands;
- overflow at the signed extremes;
- the masking of B[31:5];
- the unused operation code.

The bench compares every output against a behavioural reference built on wide integers.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int ALU_W = 32;

  typedef enum logic [3:0] {
    OPC_ADD = 4'b0000,
    OPC_SUB = 4'b0001,
    OPC_AND = 4'b0010,
    OPC_OR  = 4'b0011,
    OPC_NOR = 4'b0100,
    OPC_XOR = 4'b0101,
    OPC_SLL = 4'b0110,
    OPC_SRL = 4'b0111,
    OPC_SRA = 4'b1000,
    OPC_ROL = 4'b1001,
    OPC_ROR = 4'b1010,
    OPC_EQ  = 4'b1011,
    OPC_NE  = 4'b1100,
    OPC_GE  = 4'b1101,
    OPC_LT  = 4'b1110,
    OPC_NUL = 4'b1111
  } alu_opc_e;

  typedef enum logic [1:0] {
    LGC_AND = 2'd0,
    LGC_OR  = 2'd1,
    LGC_NOR = 2'd2,
    LGC_XOR = 2'd3
  } logic_sel_e;

  typedef enum logic [2:0] {
    SHF_LL  = 3'd0,
    SHF_RL  = 3'd1,
    SHF_RA  = 3'd2,
    SHF_ROL = 3'd3,
    SHF_ROR = 3'd4
  } shift_sel_e;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_NE = 2'd1,
    REL_GE = 2'd2,
    REL_LT = 2'd3
  } rel_sel_e;

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);

  localparam int XW = WIDTH + 1;

  // Widened add with a carry-in: the top bit of the return is the carry out.
  function automatic logic [XW-1:0] add_ci(input logic [WIDTH-1:0] x,
                                           input logic [WIDTH-1:0] y,
                                           input logic cin);
    add_ci = {1'b0, x} + {1'b0, y} + {{(XW-1){1'b0}}, cin};
  endfunction

  // Signed overflow from the sign bits of both addends and the sum.
  function automatic logic sgn_ovf(input logic sx, input logic sy, input logic ss);
    sgn_ovf = (sx == sy) && (ss != sx);
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [XW-1:0]    wide;

  assign b_eff = do_sub ? ~b : b;
  assign wide  = add_ci(a, b_eff, do_sub);
  assign sum   = wide[WIDTH-1:0];
  assign carry = wide[XW-1];
  assign ovf   = sgn_ovf(a[WIDTH-1], b_eff[WIDTH-1], sum[WIDTH-1]);

  always_comb begin
    AST_SUM_MATCHES: assert (sum == (do_sub ? a - b : a + b)); // R1
    AST_OVF_SIGN: assert (!ovf || (sum[WIDTH-1] != a[WIDTH-1])); // R3
  end

endmodule

// File: rtl/alu32_compare.sv
module alu32_compare
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  rel_sel_e         rel,
  output logic             holds,
  output logic             is_eq,
  output logic             is_ne,
  output logic             is_ge,
  output logic             is_lt
);

  // Signed less-than: on differing signs the negative operand is smaller.
  function automatic logic sgn_less(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    if (x[WIDTH-1] != y[WIDTH-1]) sgn_less = x[WIDTH-1];
    else                          sgn_less = x[WIDTH-2:0] < y[WIDTH-2:0];
  endfunction

  assign is_eq = (a == b);
  assign is_ne = |(a ^ b);
  assign is_lt = sgn_less(a, b);
  assign is_ge = sgn_less(b, a) || is_eq;

  always_comb begin
    unique case (rel)
      REL_EQ:  holds = is_eq;
      REL_NE:  holds = is_ne;
      REL_GE:  holds = is_ge;
      REL_LT:  holds = is_lt;
      default: holds = 1'b0;
    endcase
  end

  always_comb begin
    AST_EQ_NE_EXCL: assert (is_eq != is_ne); // R9
    AST_GE_LT_EXCL: assert (is_ge != is_lt); // R10
  end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_sel_e       sel,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] v_and, v_or, v_nor, v_xor;

  assign v_and = a & b;
  assign v_or  = a | b;
  assign v_nor = ~(a | b);
  assign v_xor = a ^ b;

  always_comb begin
    unique case (sel)
      LGC_AND: y = v_and;
      LGC_OR:  y = v_or;
      LGC_NOR: y = v_nor;
      LGC_XOR: y = v_xor;
      default: y = '0;
    endcase
  end

  always_comb begin
    AST_AND_IN_OR: assert ((v_and & ~v_or) == '0); // R6
    AST_XOR_SPLIT: assert ((v_xor | v_and | v_nor) == '1); // R6
  end

endmodule

// File: rtl/alu32_shift.sv
module alu32_shift
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  shift_sel_e       mode,
  output logic [WIDTH-1:0] y
);

  // Stage k moves the word by 2**k positions when amount bit k is set.
  logic [WIDTH-1:0] stg [0:SHW];
  assign stg[0] = a;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [WIDTH-1:0] cur, nxt;
    assign cur = stg[k];
    always_comb begin
      nxt = cur;
      if (amt[k]) begin
        unique case (mode)
          SHF_LL:  nxt = {cur[WIDTH-1-D:0], {D{1'b0}}};
          SHF_RL:  nxt = {{D{1'b0}}, cur[WIDTH-1:D]};
          SHF_RA:  nxt = {{D{cur[WIDTH-1]}}, cur[WIDTH-1:D]};
          SHF_ROL: nxt = {cur[WIDTH-1-D:0], cur[WIDTH-1:WIDTH-D]};
          SHF_ROR: nxt = {cur[D-1:0], cur[WIDTH-1:D]};
          default: nxt = cur;
        endcase
      end
    end
    assign stg[k+1] = nxt;
  end

  assign y = stg[SHW];

  always_comb begin
    AST_ZERO_AMT_PASS: assert (amt != '0 || y == a); // R7
    AST_SRA_SIGN: assert (mode != SHF_RA || y[WIDTH-1] == a[WIDTH-1]); // R7
    AST_ROT_POPCOUNT: assert (!(mode == SHF_ROL || mode == SHF_ROR) || $countones(y) == $countones(a)); // R8
  end

endmodule

// File: rtl/alu32_flags.sv
module alu32_flags
  import alu32_pkg::*;
(
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [3:0]  op_code,
  output logic [31:0] result,
  output logic        flag_carry,
  output logic        flag_zero,
  output logic        flag_ovf
);

  localparam int W   = ALU_W;
  localparam int SHW = $clog2(W);

  alu_opc_e   opc;
  logic       is_arith, is_sub;
  logic_sel_e lsel;
  shift_sel_e ssel;
  rel_sel_e   rsel;

  logic [W-1:0] as_sum, lg_y, sh_y;
  logic         as_carry, as_ovf;
  logic         cmp_holds, cmp_eq, cmp_ne, cmp_ge, cmp_lt;

  assign opc      = alu_opc_e'(op_code);
  assign is_sub   = (opc == OPC_SUB);
  assign is_arith = (opc == OPC_ADD) || is_sub;

  // Decode of the sub-unit selects.
  always_comb begin
    lsel = LGC_AND;
    ssel = SHF_LL;
    rsel = REL_EQ;
    unique case (opc)
      OPC_OR:  lsel = LGC_OR;
      OPC_NOR: lsel = LGC_NOR;
      OPC_XOR: lsel = LGC_XOR;
      OPC_SRL: ssel = SHF_RL;
      OPC_SRA: ssel = SHF_RA;
      OPC_ROL: ssel = SHF_ROL;
      OPC_ROR: ssel = SHF_ROR;
      OPC_NE:  rsel = REL_NE;
      OPC_GE:  rsel = REL_GE;
      OPC_LT:  rsel = REL_LT;
      default: ;
    endcase
  end

  alu32_addsub #(.WIDTH(W)) u_addsub (
    .a(op_a), .b(op_b), .do_sub(is_sub),
    .sum(as_sum), .carry(as_carry), .ovf(as_ovf)
  );

  alu32_logic #(.WIDTH(W)) u_logic (
    .a(op_a), .b(op_b), .sel(lsel), .y(lg_y)
  );

  alu32_shift #(.WIDTH(W)) u_shift (
    .a(op_a), .amt(op_b[SHW-1:0]), .mode(ssel), .y(sh_y)
  );

  alu32_compare #(.WIDTH(W)) u_cmp (
    .a(op_a), .b(op_b), .rel(rsel), .holds(cmp_holds),
    .is_eq(cmp_eq), .is_ne(cmp_ne), .is_ge(cmp_ge), .is_lt(cmp_lt)
  );

  // Result steering.
  always_comb begin
    unique case (opc)
      OPC_ADD, OPC_SUB:                            result = as_sum;
      OPC_AND, OPC_OR, OPC_NOR, OPC_XOR:           result = lg_y;
      OPC_SLL, OPC_SRL, OPC_SRA, OPC_ROL, OPC_ROR: result = sh_y;
      OPC_EQ, OPC_NE, OPC_GE, OPC_LT:              result = {{(W-1){1'b0}}, cmp_holds};
      default:                                     result = '0;
    endcase
  end

  assign flag_zero  = ~|result;
  assign flag_carry = is_arith & as_carry;
  assign flag_ovf   = is_arith & as_ovf;

  always_comb begin
    AST_QUIET_FLAGS: assert (is_arith || (!flag_carry && !flag_ovf)); // R5
    AST_NUL_ZERO: assert (opc != OPC_NUL || flag_zero); // R11
    AST_REL_BOOL: assert (!(opc inside {OPC_EQ, OPC_NE, OPC_GE, OPC_LT}) || result[W-1:1] == '0); // R9
    AST_ZERO_DIFF_EQ: assert (opc != OPC_SUB || flag_zero == cmp_eq); // R4
  end

endmodule

// File: tb/alu32_flags_test.sv
module alu32_flags_test;

  logic        clk = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  op_code = '0;
  logic [31:0] result;
  logic        flag_carry, flag_zero, flag_ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  alu32_flags uut (
    .op_a(op_a), .op_b(op_b), .op_code(op_code), .result(result),
    .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_ovf(flag_ovf)
  );

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R6";
      4'd6, 4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      4'd13, 4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference: wide integers, no shared structure with the design.
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c,
                       output logic [31:0] r, output logic cy, output logic ov);
    longint sa, sb, s;
    logic [63:0] ww;
    int amt;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    amt = int'(b[4:0]);
    cy = 0; ov = 0; r = '0;
    case (c)
      4'd0: begin
        ww = {32'd0, a} + {32'd0, b};
        r = ww[31:0]; cy = ww[32];
        s = sa + sb; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd1: begin
        ww = {32'd0, a} + {32'd0, ~b} + 64'd1;
        r = ww[31:0]; cy = ww[32];
        s = sa - sb; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = ~(a | b);
      4'd5: r = a ^ b;
      4'd6: r = a << amt;
      4'd7: r = a >> amt;
      4'd8: r = 32'(sa >>> amt);
      4'd9: begin ww = {a, a} << amt; r = ww[63:32]; end
      4'd10: begin ww = {a, a} >> amt; r = ww[31:0]; end
      4'd11: r = (a == b) ? 32'd1 : 32'd0;
      4'd12: r = (a != b) ? 32'd1 : 32'd0;
      4'd13: r = (sa >= sb) ? 32'd1 : 32'd0;
      4'd14: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [31:0] er;
    logic ec, eo, ez;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; op_code = c;
    @(negedge clk);
    model(a, b, c, er, ec, eo);
    ez = (er == 32'd0);
    n_chk++;
    if (result !== er) begin
      n_fail++;
      $display("FAIL %s result op=%0d a=%h b=%h: got %h expected %h", req_of(c), c, a, b, result, er);
    end
    n_chk++;
    if (flag_zero !== ez) begin
      n_fail++;
      $display("FAIL R4 zero op=%0d a=%h b=%h: got %b expected %b", c, a, b, flag_zero, ez);
    end
    n_chk++;
    if (flag_carry !== ec || flag_ovf !== eo) begin
      n_fail++;
      $display("FAIL %s carry/ovf op=%0d a=%h b=%h: got %b%b expected %b%b",
               (c > 4'd1) ? "R5" : "R3", c, a, b, flag_carry, flag_ovf, ec, eo);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Idle state: all-zero inputs perform ADD 0+0, so the zero flag is set (R4).
    run(32'd0, 32'd0, 4'd0);
    // R1 carry out and R3 overflow at the extremes.
    run(32'hFFFF_FFFF, 32'd1, 4'd0);
    run(32'h7FFF_FFFF, 32'd1, 4'd0);
    run(32'h8000_0000, 32'h8000_0000, 4'd0);
    // R2 carry as not-borrow, R3 subtract overflow.
    run(32'd5, 32'd5, 4'd1);
    run(32'd3, 32'd5, 4'd1);
    run(32'h8000_0000, 32'd1, 4'd1);
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd1);
    // R6 logic.
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd2);
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd3);
    run(32'hFFFF_FFFF, 32'd0, 4'd4);
    run(32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd5);
    // R7 shifts: zero amount, upper B bits ignored, sign fill.
    run(32'h8765_4321, 32'hFFFF_FFE0, 4'd6);
    run(32'h8765_4321, 32'h0000_0104, 4'd7);
    run(32'h8000_0000, 32'd31, 4'd8);
    run(32'h8000_0001, 32'd31, 4'd6);
    run(32'h4000_0000, 32'd1, 4'd8);
    // R8 rotates.
    run(32'h8000_0001, 32'd1, 4'd9);
    run(32'h8000_0001, 32'hFFFF_FF01, 4'd10);
    run(32'h1234_5678, 32'd16, 4'd9);
    // R9 / R10 relations.
    run(32'd7, 32'd7, 4'd11);
    run(32'd7, 32'd7, 4'd12);
    run(32'hFFFF_FFFF, 32'd1, 4'd13);
    run(32'hFFFF_FFFF, 32'd1, 4'd14);
    run(32'd1, 32'd1, 4'd13);
    // R11 unused code.
    run(32'hDEAD_BEEF, 32'h1234_5678, 4'd15);
    // R5 with a sum that would carry, on non-arithmetic codes.
    for (int c = 2; c < 16; c++) run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(c));
    // Random sweep across every code.
    for (int i = 0; i < 600; i++) run($urandom, $urandom, 4'($urandom_range(0, 15)));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule